// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block collects a parameterised number of active-high, level-sensitive peripheral interrupt lines and drives one interrupt request per CPU. Each CPU owns a private bank of mask bits with one bit per input line. A CPU's request is high whenever any input is high while that CPU's mask bit for the input is clear. Because the banks are independent, any source can be routed to any subset of CPUs.

Software reaches the block over a 32-bit register bus that has a read strobe, a write strobe and a word address. Masks are never written directly. A write to a "mask-on" word sets the mask bits where the data has ones. A write to a "mask-off" word clears them. Zero data bits leave the mask alone, so no read-modify-write is needed. The block does no prioritisation, vectoring or queuing, so software scans every status word of its window to find the pending sources.

Each CPU window spans 4·NW words, where NW = NUM_LINES/32. The window holds four groups of NW words in this order: line levels, mask state, mask-on and mask-off. Windows sit at a power-of-two stride so that the upper address bits pick the CPU.

Top module: `l1irq_ctrl`

## Requirements
- R1: While reset is low and on leaving reset, every mask bit of every CPU bank is 1 and every `cpu_irq` bit is 0.
- R2: A write to mask-on word w of CPU c (offset 2·NW+w) sets mask bits w·32+i of that CPU where data bit i is 1. Bits whose data is 0 keep their value.
- R3: A write to mask-off word w of CPU c (offset 3·NW+w) clears mask bits w·32+i of that CPU where data bit i is 1. Bits whose data is 0 keep their value. If a set and a clear of the same bit meet in one cycle, the clear wins.
- R4: `cpu_irq[c]` equals, one clock later, the OR over all lines of (`irq_in` AND NOT mask of CPU c).
- R5: Mask writes addressed to one CPU's window leave every other CPU's mask bank and request unchanged.
- R6: A read of line-level word w (offset w) returns `irq_in[w·32+31 : w·32]`, whatever the masks hold. A read of mask-state word w (offset NW+w) returns CPU c's mask bits for that word.
- R7: Writes to line-level and mask-state words change nothing. Reads of mask-on and mask-off words return 0.
- R8: The word address is split as CPU index = addr[WIN_AW +: CPU_W] and offset = addr[WIN_AW-1:0], with WIN_AW = clog2(4·NW). Offsets of 4·NW and above, CPU indexes of NUM_CPUS and above, and nonzero higher address bits read as 0 and ignore writes.
- R9: `bus_rdata` carries the read value in the cycle after `bus_rd` was sampled high. In any cycle that follows a cycle without a read it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Level interrupt inputs, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt requests, registered |

## Verification
The bench builds the block with NUM_LINES = 96 and NUM_CPUS = 2. Three status words per group do not divide the 16-word window evenly, so the modulo decode of group and word gets a real workout. The same choice leaves offsets 12 to 15 of each window unmapped, which puts the dead-address rule within reach. Two CPUs are the fewest needed to show that one bank's mask writes cannot leak into the other. An address with its top bits set covers the out-of-range rule.

// File: rtl/l1irq_pkg.sv
package l1irq_pkg;

  localparam int WORD_W = 32;

  // Register groups inside one CPU window, in address order.
  typedef enum logic [1:0] {
    GRP_LEVEL = 2'd0,
    GRP_MSTAT = 2'd1,
    GRP_MON   = 2'd2,
    GRP_MOFF  = 2'd3
  } grp_e;

  function automatic int words_for(int lines);
    return lines / WORD_W;
  endfunction

  function automatic int win_words(int lines);
    return 4 * words_for(lines);
  endfunction

  function automatic grp_e grp_of(int off, int nw);
    logic [1:0] g;
    g = 2'(off / nw);
    return grp_e'(g);
  endfunction

  function automatic int word_of(int off, int nw);
    return off % nw;
  endfunction

  // Next mask state: clear dominates set.
  function automatic logic [WORD_W-1:0] mask_next(logic [WORD_W-1:0] cur,
                                                  logic [WORD_W-1:0] on_bits,
                                                  logic [WORD_W-1:0] off_bits);
    return (cur | on_bits) & ~off_bits;
  endfunction

endpackage

// File: rtl/l1irq_mask_bank.sv
module l1irq_mask_bank
  import l1irq_pkg::*;
#(
  parameter int NUM_LINES = 160
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] on_bits,
  input  logic [NUM_LINES-1:0] off_bits,
  output logic [NUM_LINES-1:0] mask_q
);
  localparam int NW = words_for(NUM_LINES);

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[w*WORD_W +: WORD_W] <= '1;
      else
        mask_q[w*WORD_W +: WORD_W] <= mask_next(mask_q[w*WORD_W +: WORD_W],
                                                on_bits[w*WORD_W +: WORD_W],
                                                off_bits[w*WORD_W +: WORD_W]);
    end
  end

endmodule

// File: rtl/l1irq_req_out.sv
module l1irq_req_out #(
  parameter int NUM_LINES = 160
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] mask,
  output logic [NUM_LINES-1:0] pend,
  output logic                 req_q
);
  assign pend = irq_in & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= |pend;
  end

endmodule

// File: rtl/l1irq_regif.sv
module l1irq_regif
  import l1irq_pkg::*;
#(
  parameter int NUM_LINES = 160,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [WORD_W-1:0]             bus_wdata,
  input  logic [NUM_LINES-1:0]          irq_in,
  input  logic [NUM_CPUS*NUM_LINES-1:0] mask_all,
  output logic [NUM_CPUS*NUM_LINES-1:0] on_all,
  output logic [NUM_CPUS*NUM_LINES-1:0] off_all,
  output logic [WORD_W-1:0]             bus_rdata
);
  localparam int NW     = words_for(NUM_LINES);
  localparam int WIN    = win_words(NUM_LINES);
  localparam int WIN_AW = $clog2(WIN);
  localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int LOW_W  = WIN_AW + CPU_W;

  logic [CPU_W-1:0]  sel_cpu;
  logic [WIN_AW-1:0] sel_off;
  logic              hi_zero;
  logic              in_range;
  grp_e              sel_grp;
  int                sel_word;
  logic [WORD_W-1:0] rd_val;

  assign sel_cpu = bus_addr[WIN_AW +: CPU_W];
  assign sel_off = bus_addr[WIN_AW-1:0];

  if (ADDR_W > LOW_W) begin : g_hi
    assign hi_zero = ~|bus_addr[ADDR_W-1:LOW_W];
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  assign in_range = hi_zero && (int'(sel_cpu) < NUM_CPUS) && (int'(sel_off) < WIN);
  assign sel_grp  = grp_of(int'(sel_off), NW);
  assign sel_word = word_of(int'(sel_off), NW);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar w = 0; w < NW; w++) begin : g_word
      logic hit;
      assign hit = bus_wr && in_range && (sel_cpu == CPU_W'(c)) && (sel_word == w);
      assign on_all [c*NUM_LINES + w*WORD_W +: WORD_W] =
        (hit && sel_grp == GRP_MON)  ? bus_wdata : '0;
      assign off_all[c*NUM_LINES + w*WORD_W +: WORD_W] =
        (hit && sel_grp == GRP_MOFF) ? bus_wdata : '0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_range) begin
      case (sel_grp)
        GRP_LEVEL: rd_val = irq_in[sel_word*WORD_W +: WORD_W];
        GRP_MSTAT: rd_val = mask_all[int'(sel_cpu)*NUM_LINES + sel_word*WORD_W +: WORD_W];
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/l1irq_ctrl.sv
module l1irq_ctrl
  import l1irq_pkg::*;
#(
  parameter int NUM_LINES = 160,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_CPUS-1:0]  cpu_irq
);
  localparam int TOTAL = NUM_CPUS * NUM_LINES;

  // Named internal events, visible to the bound checker.
  logic [TOTAL-1:0] mask_all;
  logic [TOTAL-1:0] on_all;
  logic [TOTAL-1:0] off_all;
  logic [TOTAL-1:0] pend_all;

  l1irq_regif #(
    .NUM_LINES(NUM_LINES),
    .NUM_CPUS (NUM_CPUS),
    .ADDR_W   (ADDR_W)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq_in   (irq_in),
    .mask_all (mask_all),
    .on_all   (on_all),
    .off_all  (off_all),
    .bus_rdata(bus_rdata)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    l1irq_mask_bank #(.NUM_LINES(NUM_LINES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .on_bits (on_all [c*NUM_LINES +: NUM_LINES]),
      .off_bits(off_all[c*NUM_LINES +: NUM_LINES]),
      .mask_q  (mask_all[c*NUM_LINES +: NUM_LINES])
    );

    l1irq_req_out #(.NUM_LINES(NUM_LINES)) u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .irq_in(irq_in),
      .mask  (mask_all[c*NUM_LINES +: NUM_LINES]),
      .pend  (pend_all[c*NUM_LINES +: NUM_LINES]),
      .req_q (cpu_irq[c])
    );
  end

endmodule

// File: rtl/l1irq_ctrl_chk.sv
module l1irq_ctrl_chk #(
  parameter int NUM_LINES = 160,
  parameter int NUM_CPUS  = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_LINES-1:0]          irq_in,
  input logic                          bus_rd,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_CPUS-1:0]           cpu_irq,
  input logic [NUM_CPUS*NUM_LINES-1:0] mask_all,
  input logic [NUM_CPUS*NUM_LINES-1:0] on_all,
  input logic [NUM_CPUS*NUM_LINES-1:0] off_all
);
  localparam int TOTAL = NUM_CPUS * NUM_LINES;

  // R1: banks come out of reset fully masked
  p_reset_masked_r1: assert property (@(posedge clk)
    !rst_n |=> (&mask_all));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (cpu_irq == '0));

  for (genvar b = 0; b < TOTAL; b++) begin : g_bit
    p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (on_all[b] && !off_all[b]) |=> mask_all[b]);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_all[b] && !off_all[b]) |=> $stable(mask_all[b]));

    p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      off_all[b] |=> !mask_all[b]);
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    p_req_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] == $past(|(irq_in & ~mask_all[c*NUM_LINES +: NUM_LINES])));
  end

  p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind l1irq_ctrl l1irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES),
  .NUM_CPUS (NUM_CPUS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_in   (irq_in),
  .bus_rd   (bus_rd),
  .bus_rdata(bus_rdata),
  .cpu_irq  (cpu_irq),
  .mask_all (mask_all),
  .on_all   (on_all),
  .off_all  (off_all)
);

// File: tb/l1irq_ctrl_test.sv
`timescale 1ns/1ps
module l1irq_ctrl_test;
  localparam int NL   = 96;
  localparam int NC   = 2;
  localparam int AW   = 8;
  localparam int NWB  = 3;    // words per group
  localparam int STR  = 16;   // window stride in words

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] cpu_irq;

  int n_run  = 0;
  int n_fail = 0;

  logic [NL-1:0] mdl_mask [NC];

  typedef struct {
    string       req;
    logic [31:0] exp;
  } rd_item_t;
  rd_item_t sb_q [$];
  logic     rd_seen = 1'b0;

  always #2 clk = ~clk;

  l1irq_ctrl #(.NUM_LINES(NL), .NUM_CPUS(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [AW-1:0] adr(int cpu, int grp, int w);
    return AW'(cpu * STR + grp * NWB + w);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic mdl_req(int c);
    return |(irq_in & ~mdl_mask[c]);
  endfunction

  task automatic check_irq(string req);
    for (int c = 0; c < NC; c++)
      check(req, 32'(cpu_irq[c]), 32'(mdl_req(c)));
  endtask

  // Monitor: pops one expected item per completed read.
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R9: actual %h expected <no read queued>", bus_rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(it.req, bus_rdata, it.exp);
      end
    end
  end

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, logic [31:0] exp, string req);
    rd_item_t it;
    @(negedge clk);
    it.req = req; it.exp = exp;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic mask_on(int c, int w, logic [31:0] d);
    bus_write(adr(c, 2, w), d);
    mdl_mask[c][w*32 +: 32] = mdl_mask[c][w*32 +: 32] | d;
  endtask

  task automatic mask_off(int c, int w, logic [31:0] d);
    bus_write(adr(c, 3, w), d);
    mdl_mask[c][w*32 +: 32] = mdl_mask[c][w*32 +: 32] & ~d;
  endtask

  initial begin
    #(4 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) mdl_mask[c] = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 32'(cpu_irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(cpu_irq), 32'd0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NWB; w++)
        bus_read(adr(c, 1, w), 32'hFFFF_FFFF, "R1");

    // R6: levels visible regardless of mask; R4: all masked -> no request
    irq_in = {32'hA5A5_0F0F, 32'h0000_0030, 32'h8000_0001};
    for (int w = 0; w < NWB; w++)
      bus_read(adr(0, 0, w), irq_in[w*32 +: 32], "R6");
    bus_read(adr(1, 0, 2), irq_in[64 +: 32], "R6");
    @(negedge clk);
    check_irq("R4");

    // R3: unmask one bit of CPU0 word 1; R5: CPU1 untouched
    mask_off(0, 1, 32'h0000_0010);
    @(negedge clk);
    check("R3", 32'(cpu_irq[0]), 32'd1);
    check("R5", 32'(cpu_irq[1]), 32'd0);
    bus_read(adr(0, 1, 1), 32'hFFFF_FFEF, "R3");
    bus_read(adr(1, 1, 1), 32'hFFFF_FFFF, "R5");
    bus_read(adr(0, 1, 0), 32'hFFFF_FFFF, "R3");

    // R2: partial set leaves zero-data bits alone
    mask_off(0, 1, 32'h0000_0020);
    mask_on(0, 1, 32'h0000_0010);
    @(negedge clk);
    check("R2", 32'(cpu_irq[0]), 32'(mdl_req(0)));
    bus_read(adr(0, 1, 1), 32'hFFFF_FFDF, "R2");
    check_irq("R2");

    // R4: one-clock latency on input rise and fall
    mask_off(1, 2, 32'h0001_0000);
    @(negedge clk);
    irq_in[80] = 1'b0;
    @(negedge clk);
    check("R4", 32'(cpu_irq[1]), 32'd0);
    irq_in[80] = 1'b1;
    check("R4", 32'(cpu_irq[1]), 32'd0);   // before the edge
    @(negedge clk);
    check("R4", 32'(cpu_irq[1]), 32'd1);   // one clock later
    check("R5", 32'(cpu_irq[0]), 32'(mdl_req(0)));
    irq_in[80] = 1'b0;
    @(negedge clk);
    check("R4", 32'(cpu_irq[1]), 32'd0);

    // R7: writes to level and mask-state words ignored; on/off read zero
    bus_write(adr(1, 0, 2), 32'h0000_0000);
    bus_write(adr(1, 1, 2), 32'hFFFF_FFFF);
    bus_read(adr(1, 1, 2), mdl_mask[1][64 +: 32], "R7");
    bus_read(adr(1, 0, 2), irq_in[64 +: 32], "R7");
    bus_read(adr(0, 2, 1), 32'd0, "R7");
    bus_read(adr(0, 3, 1), 32'd0, "R7");

    // R8: unmapped offsets and high addresses
    bus_write(AW'(0 * STR + 13), 32'hFFFF_FFFF);
    bus_write(AW'(8'h80 + 1 * STR + 2 * NWB), 32'hFFFF_FFFF);
    bus_read(AW'(0 * STR + 12), 32'd0, "R8");
    bus_read(AW'(8'h80 + 0 * STR), 32'd0, "R8");
    bus_read(adr(1, 1, 0), mdl_mask[1][0 +: 32], "R8");
    bus_read(adr(0, 1, 0), mdl_mask[0][0 +: 32], "R8");
    bus_read(adr(1, 1, 2), mdl_mask[1][64 +: 32], "R8");
    // R8: last word of CPU1 window controls lines 64..95
    irq_in = '0;
    irq_in[95] = 1'b1;
    mask_off(1, 2, 32'h8000_0000);
    @(negedge clk);
    check("R8", 32'(cpu_irq[1]), 32'd1);
    check("R8", 32'(cpu_irq[0]), 32'd0);
    mask_on(1, 2, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R2", 32'(cpu_irq[1]), 32'd0);

    // R9: idle read data is zero
    @(negedge clk);
    check("R9", bus_rdata, 32'd0);

    repeat (3) @(negedge clk);
    check("R9", 32'(sb_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule